// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block runs beside a pipelined core and decides when the core stops for debug and when it runs again. It gathers halt causes from four places: an external breakpoint pin, a level-sensitive debug request pin, and two comparator units. Each comparator unit can watch either the address in the execute stage (a breakpoint) or data writes (a watchpoint). When a cause is taken, the block stalls the core and raises a debug acknowledge. For breakpoint-type causes it also freezes the program counter, so the stopped instruction keeps its own address.

Causes that belong to an instruction in flight act at once, in the same cycle. These are the external breakpoint and an execute-address match. Causes that must let the current instruction finish wait for the core's instruction-complete strobe. These are a debug request and a data watchpoint. A data watchpoint counts only when the write actually changes the stored value. A one-hot status value records which cause stopped the core. A restart pulse releases the core, provided the debug request is not also held high.

Top module: `dbg_halt_unit`

## Requirements
- R1: While running, a high `extBreak` raises `haltCore` and `pcHold` in the same cycle. `dbgAck` rises on the next clock edge, and the cause is external breakpoint.
- R2: While running, a high `dbgReq` does not halt the core until a cycle with `instDone` high. In that cycle `haltCore` rises with `pcHold` low. `dbgAck` follows on the next edge.
- R3: `dbgAck` is a registered flag that is high exactly while the block is in debug state. `haltCore` is high in every cycle that `dbgAck` is high.
- R4: A unit in instruction mode hits when `exValid` is high and `((exAddr ^ value) & ~mask) == 0`. A set mask bit means "ignore this bit". A hit acts like R1: `haltCore` and `pcHold` rise in the same cycle. `pcHold` then stays high for the whole halt.
- R5: A unit in data mode arms only on a write with `dataWrEn` high, a masked address match on `dataAddr`, and `dataNew != dataOld`. An armed unit halts the core in the first cycle that has `instDone` high, with `pcHold` low. A write that leaves the value unchanged, or that goes to another address, never halts.
- R6: Control register, written at configuration address 0: bit 2u enables unit u, and bit 2u+1 selects data mode (1) or instruction mode (0). A disabled unit never halts the core.
- R7: Configuration writes happen when `cfgWe` is high at a clock edge. Unit u takes its compare value from address 1+2u and its mask from address 2+2u.
- R8: `haltCause` is one-hot: bit 0 external breakpoint, bit 1 unit 0, bit 2 unit 1, bit 3 debug request. It is loaded on halt entry. New causes that arrive while halted do not change it, and it keeps its value after restart.
- R9: When several causes arrive in the same cycle, the winner in order is external breakpoint, then unit 0, then unit 1, then debug request.
- R10: A restart pulse while halted, with `dbgReq` low, clears `dbgAck`, `haltCore` and `pcHold` from the next edge on.
- R11: A restart while `dbgReq` is high is ignored, and the block stays halted.
- R12: A low `rstN` at a clock edge clears the debug state, the cause, the configuration and any armed watchpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| extBreak | input | 1 | External breakpoint, active high |
| dbgReq | input | 1 | Debug request level |
| instDone | input | 1 | Core reports the current instruction completed |
| exValid | input | 1 | Execute stage holds a valid instruction |
| exAddr | input | ADDR_W | Address of the instruction in execute |
| dataWrEn | input | 1 | Core performs a data write this cycle |
| dataAddr | input | ADDR_W | Data write address |
| dataNew | input | DATA_W | Value being written |
| dataOld | input | DATA_W | Value previously stored at that address |
| restart | input | 1 | Pulse to leave debug state |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select |
| cfgData | input | ADDR_W | Configuration write data |
| haltCore | output | 1 | Stall the core (entry cycle and whole halt) |
| pcHold | output | 1 | Keep the PC at the stopped instruction |
| dbgAck | output | 1 | Debug state acknowledge |
| haltCause | output | 4 | One-hot cause of the latest halt |

## Verification
Two causes that can land in the same cycle are an immediate cause and a deferred one. One example is the external breakpoint against a debug request that meets `instDone`. Another is a unit-1 address hit against that same request. Two address units matching the same execute address form a third pair. The bench drives each pair in a single cycle and judges the winner from `haltCause` one edge later. It also checks whether `pcHold` follows the winner's kind, which shows that the losing cause had no effect on the PC freeze.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  localparam int NUM_UNITS = 2;
  localparam int CAUSE_W   = NUM_UNITS + 2;
  localparam int CTRL_W    = 2 * NUM_UNITS;
  localparam int CFG_AW    = 3;

  // cause bit positions, lowest index wins
  localparam int CAUSE_EXT = 0;
  localparam int CAUSE_REQ = CAUSE_W - 1;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } dbgState_t;

  // datapath -> control
  typedef struct packed {
    logic [NUM_UNITS-1:0] brkHit;
    logic [NUM_UNITS-1:0] watchLive;
    logic [NUM_UNITS-1:0] watchPend;
  } hitInfo_t;

  // control -> datapath
  typedef struct packed {
    logic               armed;
    logic               capture;
    logic               clearPend;
    logic [CAUSE_W-1:0] causeSel;
  } ctlStrobe_t;

endpackage

// File: rtl/dbg_wp_unit.sv
module dbg_wp_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrVal,
  input  logic              wrMask,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              enable,
  input  logic              dataMode,
  input  logic              exValid,
  input  logic [ADDR_W-1:0] exAddr,
  input  logic              dataWrEn,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataNew,
  input  logic [DATA_W-1:0] dataOld,
  output logic              brkHit,
  output logic              watchHit
);

  logic [ADDR_W-1:0] matchVal;
  logic [ADDR_W-1:0] matchMask;
  logic              exEq;
  logic              dataEq;
  logic              valueChanged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchVal  <= '0;
      matchMask <= '0;
    end else begin
      if (wrVal)  matchVal  <= wrData;
      if (wrMask) matchMask <= wrData;
    end
  end

  // set mask bits are don't-care positions
  always_comb begin
    exEq         = ((exAddr   ^ matchVal) & ~matchMask) == '0;
    dataEq       = ((dataAddr ^ matchVal) & ~matchMask) == '0;
    valueChanged = dataNew != dataOld;
    brkHit       = enable && !dataMode && exValid && exEq;
    watchHit     = enable && dataMode && dataWrEn && dataEq && valueChanged;
  end

endmodule

// File: rtl/dbg_halt_dp.sv
module dbg_halt_dp
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  cfgData,
  input  logic               exValid,
  input  logic [ADDR_W-1:0]  exAddr,
  input  logic               dataWrEn,
  input  logic [ADDR_W-1:0]  dataAddr,
  input  logic [DATA_W-1:0]  dataNew,
  input  logic [DATA_W-1:0]  dataOld,
  input  ctlStrobe_t         strobe,
  output hitInfo_t           hit,
  output logic [CAUSE_W-1:0] haltCause
);

  logic [CTRL_W-1:0]    ctrlReg;
  logic [NUM_UNITS-1:0] brkHit;
  logic [NUM_UNITS-1:0] watchHit;
  logic [NUM_UNITS-1:0] pendReg;
  logic [CAUSE_W-1:0]   causeReg;

  // control register at configuration address 0
  always_ff @(posedge clk) begin
    if (!rstN)
      ctrlReg <= '0;
    else if (cfgWe && cfgAddr == '0)
      ctrlReg <= cfgData[CTRL_W-1:0];
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic wrVal;
    logic wrMask;

    assign wrVal  = cfgWe && (cfgAddr == CFG_AW'(1 + 2 * u));
    assign wrMask = cfgWe && (cfgAddr == CFG_AW'(2 + 2 * u));

    dbg_wp_unit #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) i_unit (
      .clk      (clk),
      .rstN     (rstN),
      .wrVal    (wrVal),
      .wrMask   (wrMask),
      .wrData   (cfgData),
      .enable   (ctrlReg[2 * u]),
      .dataMode (ctrlReg[2 * u + 1]),
      .exValid  (exValid),
      .exAddr   (exAddr),
      .dataWrEn (dataWrEn),
      .dataAddr (dataAddr),
      .dataNew  (dataNew),
      .dataOld  (dataOld),
      .brkHit   (brkHit[u]),
      .watchHit (watchHit[u])
    );
  end

  // a changed-value write arms the unit until the instruction completes
  always_ff @(posedge clk) begin
    if (!rstN)
      pendReg <= '0;
    else if (strobe.clearPend)
      pendReg <= '0;
    else if (strobe.armed)
      pendReg <= pendReg | watchHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      causeReg <= '0;
    else if (strobe.capture)
      causeReg <= strobe.causeSel;
  end

  always_comb begin
    hit.brkHit    = brkHit;
    hit.watchLive = watchHit;
    hit.watchPend = pendReg;
    haltCause     = causeReg;
  end

endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extBreak,
  input  logic       dbgReq,
  input  logic       instDone,
  input  logic       restart,
  input  hitInfo_t   hit,
  output ctlStrobe_t strobe,
  output logic       haltCore,
  output logic       pcHold,
  output logic       dbgAck
);

  dbgState_t          state;
  logic               bpHold;
  logic [CAUSE_W-1:0] cand;
  logic [CAUSE_W-1:0] sel;
  logic               bpSel;
  logic               enter;
  logic               leave;

  always_comb begin
    cand            = '0;
    cand[CAUSE_EXT] = extBreak;
    for (int u = 0; u < NUM_UNITS; u++)
      cand[1 + u] = hit.brkHit[u] ||
                    (instDone && (hit.watchPend[u] || hit.watchLive[u]));
    cand[CAUSE_REQ] = instDone && dbgReq;

    // lowest index has highest priority
    sel = '0;
    for (int i = CAUSE_W - 1; i >= 0; i--)
      if (cand[i]) sel = CAUSE_W'(1) << i;

    bpSel = sel[CAUSE_EXT];
    for (int u = 0; u < NUM_UNITS; u++)
      bpSel = bpSel || (sel[1 + u] && hit.brkHit[u]);

    enter = (state == ST_RUN) && (cand != '0);
    leave = (state == ST_HALT) && restart && !dbgReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_RUN;
      bpHold <= 1'b0;
    end else if (enter) begin
      state  <= ST_HALT;
      bpHold <= bpSel;
    end else if (leave) begin
      state  <= ST_RUN;
      bpHold <= 1'b0;
    end
  end

  always_comb begin
    strobe.armed     = (state == ST_RUN);
    strobe.capture   = enter;
    strobe.clearPend = enter;
    strobe.causeSel  = sel;
    haltCore         = enter || (state == ST_HALT);
    pcHold           = (enter && bpSel) || ((state == ST_HALT) && bpHold);
    dbgAck           = (state == ST_HALT);
  end

endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extBreak,
  input  logic               dbgReq,
  input  logic               instDone,
  input  logic               exValid,
  input  logic [ADDR_W-1:0]  exAddr,
  input  logic               dataWrEn,
  input  logic [ADDR_W-1:0]  dataAddr,
  input  logic [DATA_W-1:0]  dataNew,
  input  logic [DATA_W-1:0]  dataOld,
  input  logic               restart,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  cfgData,
  output logic               haltCore,
  output logic               pcHold,
  output logic               dbgAck,
  output logic [CAUSE_W-1:0] haltCause
);

  ctlStrobe_t strobe;
  hitInfo_t   hit;

  dbg_halt_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .exValid   (exValid),
    .exAddr    (exAddr),
    .dataWrEn  (dataWrEn),
    .dataAddr  (dataAddr),
    .dataNew   (dataNew),
    .dataOld   (dataOld),
    .strobe    (strobe),
    .hit       (hit),
    .haltCause (haltCause)
  );

  dbg_halt_ctl i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .extBreak (extBreak),
    .dbgReq   (dbgReq),
    .instDone (instDone),
    .restart  (restart),
    .hit      (hit),
    .strobe   (strobe),
    .haltCore (haltCore),
    .pcHold   (pcHold),
    .dbgAck   (dbgAck)
  );

endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk
  import dbg_halt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               extBreak,
  input logic               dbgReq,
  input logic               instDone,
  input logic               restart,
  input logic               haltCore,
  input logic               pcHold,
  input logic               dbgAck,
  input logic [CAUSE_W-1:0] haltCause
);

  a_r1_ext_cause_from_pin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgAck) && haltCause[CAUSE_EXT] |-> $past(extBreak));

  a_r2_req_waits_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgAck) && haltCause[CAUSE_REQ] |-> $past(instDone) && $past(dbgReq));

  a_r3_ack_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgAck) |-> $past(haltCore));

  a_r3_stall_while_ack: assert property (@(posedge clk) disable iff (!rstN)
    dbgAck |-> haltCore);

  a_r4_hold_implies_stall: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> haltCore);

  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (!rstN)
    dbgAck |-> $countones(haltCause) == 1);

  a_r8_cause_stable: assert property (@(posedge clk) disable iff (!rstN)
    dbgAck && $past(dbgAck) |-> $stable(haltCause));

  a_r10_exit_by_restart: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dbgAck) |-> $past(restart) && !$past(dbgReq));

  a_r12_reset_clears: assert property (@(posedge clk)
    !rstN |=> !dbgAck);

endmodule

bind dbg_halt_unit dbg_halt_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .extBreak  (extBreak),
  .dbgReq    (dbgReq),
  .instDone  (instDone),
  .restart   (restart),
  .haltCore  (haltCore),
  .pcHold    (pcHold),
  .dbgAck    (dbgAck),
  .haltCause (haltCause)
);

// File: tb/test_dbg_halt_unit.sv
module test_dbg_halt_unit;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          extBreak = 1'b0;
  logic          dbgReq = 1'b0;
  logic          instDone = 1'b0;
  logic          exValid = 1'b0;
  logic [AW-1:0] exAddr = '0;
  logic          dataWrEn = 1'b0;
  logic [AW-1:0] dataAddr = '0;
  logic [DW-1:0] dataNew = '0;
  logic [DW-1:0] dataOld = '0;
  logic          restart = 1'b0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgAddr = '0;
  logic [AW-1:0] cfgData = '0;
  logic          haltCore;
  logic          pcHold;
  logic          dbgAck;
  logic [3:0]    haltCause;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dbg_halt_unit #(.ADDR_W(AW), .DATA_W(DW)) i_dbg_halt_unit (
    .clk(clk), .rstN(rstN), .extBreak(extBreak), .dbgReq(dbgReq),
    .instDone(instDone), .exValid(exValid), .exAddr(exAddr),
    .dataWrEn(dataWrEn), .dataAddr(dataAddr), .dataNew(dataNew),
    .dataOld(dataOld), .restart(restart), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .haltCore(haltCore),
    .pcHold(pcHold), .dbgAck(dbgAck), .haltCause(haltCause)
  );

  // value, mask, execute address, expected hit (unit 0, instruction mode)
  localparam logic [96:0] TBL [0:5] = '{
    {32'h0000_1000, 32'h0000_0000, 32'h0000_1000, 1'b1},
    {32'h0000_1000, 32'h0000_0000, 32'h0000_1004, 1'b0},
    {32'h0000_1000, 32'h0000_000F, 32'h0000_100C, 1'b1},
    {32'h0000_1000, 32'h0000_000F, 32'h0000_1010, 1'b0},
    {32'h0000_2000, 32'hFFFF_0000, 32'hABCD_2000, 1'b1},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic exitHalt(input string req);
    dbgReq = 1'b0; restart = 1'b1;
    tick();
    restart = 1'b0;
    chk(req, {31'b0, dbgAck}, 32'd0);
    chk(req, {30'b0, haltCore, pcHold}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    tick();
    doReset();
    // R12 reset state
    chk("R12 reset ack", {31'b0, dbgAck}, 32'd0);
    chk("R12 reset stall", {30'b0, haltCore, pcHold}, 32'd0);
    chk("R12 reset cause", {28'b0, haltCause}, 32'd0);

    // R4 R7 comparator table
    for (int i = 0; i < 6; i++) begin
      doReset();
      cfg(3'd0, 32'h1);
      cfg(3'd1, TBL[i][96:65]);
      cfg(3'd2, TBL[i][64:33]);
      exValid = 1'b1; exAddr = TBL[i][32:1];
      #1;
      chk("R4 table stall", {31'b0, haltCore}, {31'b0, TBL[i][0]});
      chk("R4 table pcHold", {31'b0, pcHold}, {31'b0, TBL[i][0]});
      tick();
      exValid = 1'b0;
      chk("R4 table ack", {31'b0, dbgAck}, {31'b0, TBL[i][0]});
      chk("R8 table cause", {28'b0, haltCause}, TBL[i][0] ? 32'h2 : 32'h0);
      if (TBL[i][0]) chk("R4 pcHold held", {31'b0, pcHold}, 32'd1);
    end

    // R2 debug request waits for completion
    doReset();
    dbgReq = 1'b1;
    tick(); tick(); tick();
    chk("R2 no halt before done", {30'b0, haltCore, dbgAck}, 32'd0);
    instDone = 1'b1;
    #1;
    chk("R2 stall on done", {30'b0, haltCore, pcHold}, 32'h2);
    tick();
    instDone = 1'b0;
    chk("R2 ack after done", {31'b0, dbgAck}, 32'd1);
    chk("R8 req cause", {28'b0, haltCause}, 32'h8);
    // R11 restart ignored while request high
    restart = 1'b1;
    tick();
    restart = 1'b0;
    tick();
    chk("R11 restart ignored", {31'b0, dbgAck}, 32'd1);
    exitHalt("R10 exit after restart");
    chk("R8 cause kept after exit", {28'b0, haltCause}, 32'h8);

    // R1 external breakpoint
    extBreak = 1'b1;
    #1;
    chk("R1 immediate stall", {30'b0, haltCore, pcHold}, 32'h3);
    chk("R1 ack not yet", {31'b0, dbgAck}, 32'd0);
    tick();
    extBreak = 1'b0;
    chk("R1 ack", {31'b0, dbgAck}, 32'd1);
    chk("R1 cause", {28'b0, haltCause}, 32'h1);
    chk("R1 pcHold kept", {31'b0, pcHold}, 32'd1);
    tick();
    chk("R3 ack while halted", {30'b0, dbgAck, haltCore}, 32'h3);
    exitHalt("R10 exit from break");

    // R9 ext beats request in same cycle
    extBreak = 1'b1; dbgReq = 1'b1; instDone = 1'b1;
    tick();
    extBreak = 1'b0; instDone = 1'b0;
    chk("R9 ext over req", {28'b0, haltCause}, 32'h1);
    exitHalt("R10 exit after prio");

    // R9 unit0 beats unit1
    cfg(3'd0, 32'h5);
    cfg(3'd1, 32'h100); cfg(3'd2, 32'h0);
    cfg(3'd3, 32'h100); cfg(3'd4, 32'h0);
    exValid = 1'b1; exAddr = 32'h100;
    tick();
    exValid = 1'b0;
    chk("R9 unit0 over unit1", {28'b0, haltCause}, 32'h2);
    // R8 new cause while halted ignored
    extBreak = 1'b1;
    tick();
    extBreak = 1'b0;
    chk("R8 cause frozen in halt", {28'b0, haltCause}, 32'h2);
    exitHalt("R10 exit units");

    // R6 only unit 1 enabled
    cfg(3'd0, 32'h4);
    cfg(3'd1, 32'h200);
    exValid = 1'b1; exAddr = 32'h200;
    #1;
    chk("R6 disabled unit0 silent", {31'b0, haltCore}, 32'd0);
    tick();
    chk("R6 no ack", {31'b0, dbgAck}, 32'd0);
    // R9 unit1 beats request
    exAddr = 32'h100; dbgReq = 1'b1; instDone = 1'b1;
    #1;
    chk("R9 bp type pcHold", {31'b0, pcHold}, 32'd1);
    tick();
    exValid = 1'b0; instDone = 1'b0;
    chk("R9 unit1 over req", {28'b0, haltCause}, 32'h4);
    exitHalt("R10 exit unit1");

    // R5 data watchpoint on unit 1
    doReset();
    cfg(3'd0, 32'hC);
    cfg(3'd3, 32'h40); cfg(3'd4, 32'h0);
    dataWrEn = 1'b1; dataAddr = 32'h40; dataNew = 32'd5; dataOld = 32'd5;
    instDone = 1'b1;
    #1;
    chk("R5 same value no halt", {31'b0, haltCore}, 32'd0);
    tick();
    dataAddr = 32'h44; dataNew = 32'd1; dataOld = 32'd0; instDone = 1'b0;
    tick();
    dataWrEn = 1'b0; instDone = 1'b1;
    #1;
    chk("R5 other address no halt", {31'b0, haltCore}, 32'd0);
    tick();
    instDone = 1'b0;
    chk("R5 no ack", {31'b0, dbgAck}, 32'd0);
    dataWrEn = 1'b1; dataAddr = 32'h40; dataNew = 32'd7; dataOld = 32'd5;
    #1;
    chk("R5 waits for done", {31'b0, haltCore}, 32'd0);
    tick();
    dataWrEn = 1'b0;
    chk("R5 armed not halted", {31'b0, dbgAck}, 32'd0);
    instDone = 1'b1;
    #1;
    chk("R5 stall on done", {30'b0, haltCore, pcHold}, 32'h2);
    tick();
    instDone = 1'b0;
    chk("R5 ack", {31'b0, dbgAck}, 32'd1);
    chk("R5 cause unit1", {28'b0, haltCause}, 32'h4);

    // R12 reset while halted
    doReset();
    chk("R12 reset clears ack", {31'b0, dbgAck}, 32'd0);
    chk("R12 reset clears cause", {28'b0, haltCause}, 32'd0);
    exValid = 1'b1; exAddr = 32'h40;
    #1;
    chk("R12 config cleared", {31'b0, haltCore}, 32'd0);
    exValid = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule